// File: doc/BRIEF.md
# Segment Credit Tracker

This block sits between a host controller and a MAC-PHY that exchange Ethernet frame data in fixed-size segments. It keeps two counts. The first is how many transmit segments the host may still push before the transmit buffer would overflow. The second is how many received segments are waiting for the host to collect. Both counts start from a known state and never go above the buffer capacity of 48 segments.

The counts appear in a 32-bit read-only status word. They also appear as 5-bit copies that saturate, ready to be placed in each receive-data footer. A host write made with no credit left sets a sticky transmit error. A network arrival that finds the receive side full is dropped and sets a sticky receive error. A host read made with nothing pending yields a segment marked invalid, unless a segment lands from the network in that same cycle. In that case the new segment is handed over directly as valid.

Top module: `seg_credit_tracker`

## Requirements
- R1: After reset the transmit credit is 48, the receive count is 0, both error flags are 0, and the status word reads 0x00003000.
- R2: A host write with credit above zero lowers the transmit credit by one, and a network drain raises it by one. When both happen in one cycle, the credit is unchanged. A drain while the credit is already 48 leaves it at 48.
- R3: A host write while the transmit credit is 0 sets the transmit error flag from the next cycle on and leaves the credit at 0.
- R4: A network arrival raises the receive count by one, and a host read with a nonzero count lowers it by one. When both happen in one cycle, the count is unchanged.
- R5: A host read while the receive count is 0 drives the valid output low in that same cycle and the count stays 0. If an arrival occurs in that same cycle, the valid output is high and the count still stays 0.
- R6: An arrival without a read while the receive count is 48 is dropped. The count stays 48 and the receive error flag is set from the next cycle. An arrival together with a read at 48 keeps the count at 48 and sets no flag.
- R7: The clear input lowers both sticky error flags on the next cycle. A new error condition in the same cycle as a clear wins, and its flag stays set.
- R8: The status word carries the transmit credit in bits 15:8 and the receive count in bits 7:0. Bits 31:16 are always zero.
- R9: Each 5-bit footer copy equals its count when the count is below 31, and equals 31 otherwise.
- R10: Neither count ever exceeds 48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host writes one transmit segment this cycle |
| net_drain | input | 1 | One transmit segment left for the network |
| net_arrive | input | 1 | One receive segment arrived from the network |
| host_rd | input | 1 | Host reads one receive segment this cycle |
| err_clr | input | 1 | Clear both sticky error flags |
| rd_valid | output | 1 | Segment being read this cycle carries valid data |
| status_word | output | 32 | Read-only status: credits 15:8, receive count 7:0 |
| footer_tx | output | 5 | Saturated transmit credit for the footer |
| footer_rx | output | 5 | Saturated receive count for the footer |
| tx_ovf_err | output | 1 | Sticky transmit overflow flag |
| rx_ovf_err | output | 1 | Sticky receive overflow flag |

## Verification
Both counters are visible one cycle after every event, through the status word and the footer copies. A wrong increment, a missed saturation or a wrong reset value therefore shows at the ports on the very next sample. A counter that drifts by one stays wrong for good, so walking the credit down to zero and the receive count up to 48 exposes it at the boundary. There, the overflow flags and the valid output fire on the wrong cycle or not at all.

// File: rtl/seg_credit_tracker.sv
module seg_credit_tracker #(
  parameter int MAX_SEGS = 48,
  parameter int CNT_W    = 8,
  parameter int FTR_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic                 net_drain,
  input  logic                 net_arrive,
  input  logic                 host_rd,
  input  logic                 err_clr,
  output logic                 rd_valid,
  output logic [31:0]          status_word,
  output logic [FTR_W-1:0]     footer_tx,
  output logic [FTR_W-1:0]     footer_rx,
  output logic                 tx_ovf_err,
  output logic                 rx_ovf_err
);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(MAX_SEGS);
  localparam logic [CNT_W-1:0] FSAT = CNT_W'((1 << FTR_W) - 1);
  localparam int               PADW = 32 - 2 * CNT_W;

  logic [CNT_W-1:0] tx_cnt, rx_cnt;

  wire tx_zero  = (tx_cnt == '0);
  wire tx_take  = host_wr && !tx_zero;
  wire tx_give  = net_drain && (tx_cnt != CAP || tx_take);
  wire tx_bad   = host_wr && tx_zero;

  wire rd_take  = host_rd && (rx_cnt != '0 || net_arrive);
  wire rx_acc   = net_arrive && (rx_cnt != CAP || rd_take);
  wire rx_bad   = net_arrive && !rx_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_cnt <= CAP;
    end else if (tx_give && !tx_take) begin
      tx_cnt <= tx_cnt + 1'b1;
    end else if (tx_take && !tx_give) begin
      tx_cnt <= tx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_cnt <= '0;
    end else if (rx_acc && !rd_take) begin
      rx_cnt <= rx_cnt + 1'b1;
    end else if (rd_take && !rx_acc) begin
      rx_cnt <= rx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_ovf_err <= 1'b0;
      rx_ovf_err <= 1'b0;
    end else begin
      tx_ovf_err <= tx_bad || (tx_ovf_err && !err_clr);
      rx_ovf_err <= rx_bad || (rx_ovf_err && !err_clr);
    end
  end

  assign rd_valid    = rd_take;
  assign status_word = {{PADW{1'b0}}, tx_cnt, rx_cnt};
  assign footer_tx   = (tx_cnt >= FSAT) ? FSAT[FTR_W-1:0] : tx_cnt[FTR_W-1:0];
  assign footer_rx   = (rx_cnt >= FSAT) ? FSAT[FTR_W-1:0] : rx_cnt[FTR_W-1:0];
endmodule

// File: rtl/seg_credit_tracker_chk.sv
module seg_credit_tracker_chk #(
  parameter int MAX_SEGS = 48,
  parameter int CNT_W    = 8,
  parameter int FTR_W    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic             net_drain,
  input logic             net_arrive,
  input logic             host_rd,
  input logic             err_clr,
  input logic             rd_valid,
  input logic [31:0]      status_word,
  input logic [FTR_W-1:0] footer_tx,
  input logic             tx_ovf_err,
  input logic             rx_ovf_err
);
  localparam logic [7:0] CAP8 = 8'(MAX_SEGS);
  wire [7:0] txc = status_word[15:8];
  wire [7:0] rxc = status_word[7:0];

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    txc <= CAP8 && rxc <= CAP8); // R10
  AST_TX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !net_drain && txc != 8'd0 |=> txc == $past(txc) - 8'd1); // R2
  AST_TX_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && txc == 8'd0 |=> tx_ovf_err); // R3
  AST_TX_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !net_drain && txc == 8'd0 |=> txc == 8'd0); // R3
  AST_RD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && rxc == 8'd0 && !net_arrive |-> !rd_valid); // R5
  AST_RX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    net_arrive && !host_rd && rxc == CAP8 |=> rx_ovf_err && rxc == CAP8); // R6
  AST_ERR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !host_wr && !net_arrive |=> !tx_ovf_err && !rx_ovf_err); // R7
  AST_FTR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    txc >= 8'd31 |-> footer_tx == 5'd31); // R9
endmodule

bind seg_credit_tracker seg_credit_tracker_chk #(
  .MAX_SEGS(MAX_SEGS), .CNT_W(CNT_W), .FTR_W(FTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .net_drain(net_drain),
  .net_arrive(net_arrive), .host_rd(host_rd), .err_clr(err_clr),
  .rd_valid(rd_valid), .status_word(status_word), .footer_tx(footer_tx),
  .tx_ovf_err(tx_ovf_err), .rx_ovf_err(rx_ovf_err)
);

// File: tb/seg_credit_tracker_tb_top.sv
module seg_credit_tracker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 0, net_drain = 0, net_arrive = 0, host_rd = 0, err_clr = 0;
  logic rd_valid, tx_ovf_err, rx_ovf_err;
  logic [31:0] status_word;
  logic [4:0] footer_tx, footer_rx;
  int n_chk = 0, n_fail = 0;
  logic cap_valid;

  always #4 clk = ~clk;

  seg_credit_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .net_drain(net_drain),
    .net_arrive(net_arrive), .host_rd(host_rd), .err_clr(err_clr),
    .rd_valid(rd_valid), .status_word(status_word), .footer_tx(footer_tx),
    .footer_rx(footer_rx), .tx_ovf_err(tx_ovf_err), .rx_ovf_err(rx_ovf_err)
  );

  // {wr, drain, arrive, rd, clr, exp_valid, exp_tx[7:0], exp_rx[7:0]}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {5'b10000, 1'b0, 8'd47, 8'd0},
    {5'b00100, 1'b0, 8'd47, 8'd1},
    {5'b00100, 1'b0, 8'd47, 8'd2},
    {5'b00010, 1'b1, 8'd47, 8'd1},
    {5'b00110, 1'b1, 8'd47, 8'd1},
    {5'b11000, 1'b0, 8'd47, 8'd1},
    {5'b01000, 1'b0, 8'd48, 8'd1},
    {5'b01000, 1'b0, 8'd48, 8'd1},
    {5'b00010, 1'b1, 8'd48, 8'd0},
    {5'b00010, 1'b0, 8'd48, 8'd0},
    {5'b00110, 1'b1, 8'd48, 8'd0},
    {5'b10100, 1'b0, 8'd47, 8'd1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic d, input logic a, input logic r, input logic c);
    @(negedge clk);
    host_wr = w; net_drain = d; net_arrive = a; host_rd = r; err_clr = c;
    #2 cap_valid = rd_valid;
    @(posedge clk);
    #2;
    host_wr = 0; net_drain = 0; net_arrive = 0; host_rd = 0; err_clr = 0;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(status_word == 32'h0000_3000, "R1 status", status_word, 32'h3000);
    chk(!tx_ovf_err && !rx_ovf_err, "R1 flags", {tx_ovf_err, rx_ovf_err}, 0);
    chk(footer_tx == 5'd31 && footer_rx == 5'd0, "R1/R9 footers", {footer_tx, footer_rx}, {5'd31, 5'd0});

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][21], VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17]);
      chk(cap_valid == VEC[i][16], "R5 valid (table)", cap_valid, VEC[i][16]);
      chk(status_word[15:8] == VEC[i][15:8], "R2 tx credit (table)", status_word[15:8], VEC[i][15:8]);
      chk(status_word[7:0] == VEC[i][7:0], "R4 rx count (table)", status_word[7:0], VEC[i][7:0]);
    end

    // drain tx credit from 47 down to 0
    for (int k = 46; k >= 0; k--) begin
      step(1, 0, 0, 0, 0);
      if (k == 30) chk(footer_tx == 5'd30, "R9 footer below sat", footer_tx, 30);
      if (k == 31) chk(footer_tx == 5'd31, "R9 footer at 31", footer_tx, 31);
    end
    chk(status_word[15:8] == 8'd0, "R2 credit at zero", status_word[15:8], 0);
    chk(!tx_ovf_err, "R3 no early flag", tx_ovf_err, 0);
    step(1, 0, 0, 0, 0);
    chk(tx_ovf_err, "R3 overflow flag", tx_ovf_err, 1);
    chk(status_word[15:8] == 8'd0, "R3 credit held", status_word[15:8], 0);
    step(0, 0, 0, 0, 1);
    chk(!tx_ovf_err, "R7 clear tx", tx_ovf_err, 0);
    step(1, 0, 0, 0, 1);
    chk(tx_ovf_err, "R7 set wins over clear", tx_ovf_err, 1);
    step(0, 0, 0, 0, 1);

    // fill rx from 1 to 48
    for (int k = 2; k <= 48; k++) step(0, 0, 1, 0, 0);
    chk(status_word[7:0] == 8'd48, "R10 rx at cap", status_word[7:0], 48);
    chk(footer_rx == 5'd31, "R9 rx footer sat", footer_rx, 31);
    step(0, 0, 1, 1, 0);
    chk(cap_valid && status_word[7:0] == 8'd48 && !rx_ovf_err, "R6 arrive+read at cap",
        {cap_valid, rx_ovf_err, status_word[7:0]}, {2'b10, 8'd48});
    step(0, 0, 1, 0, 0);
    chk(rx_ovf_err, "R6 drop flag", rx_ovf_err, 1);
    chk(status_word[7:0] == 8'd48, "R6 count held", status_word[7:0], 48);
    chk(status_word[31:16] == 16'd0, "R8 upper zero", status_word[31:16], 0);
    chk(status_word == 32'h0000_0030, "R8 layout", status_word, 32'h30);
    step(0, 0, 0, 0, 1);
    chk(!rx_ovf_err, "R7 clear rx", rx_ovf_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule